// File: doc/BRIEF.md
# Serial Flash Read Sequencer

This block is the host-side master that pulls bytes out of a serial flash over a four-wire SPI link in mode 0. The system side makes a one-cycle request that carries an opcode select, a 24-bit start address and a byte count. The block pulls chip select low and sends a header with the most significant bit first. For the streaming read the header is the opcode and three address bytes. For the page read the header is the opcode, three address bytes and four padding bytes. After the header, the block clocks in the requested number of data bytes and passes them out on a byte stream. When the last byte is in, it releases chip select.

The output stream uses valid/ready. A byte is offered with `rd_valid` and stays on `rd_data` without change until `rd_ready` is seen high on a clock edge. The block holds one byte that is waiting to be taken and can be shifting in the next byte at the same time. If both are full, it stops SCK (held low, chip select still asserted) until the consumer accepts a byte. No data is dropped and none is repeated. `rd_ready` may stay low for any length of time. Control uses plain pins: `req` is sampled only while `busy` is low, and `done` pulses once for each accepted request.

Top module: `spi_flash_reader`

## Requirements
- R1: With `req_page`=0 the header is four bytes: 0x03, then address bits 23:16, 15:8 and 7:0. The first data bit is sampled on the very next SCK rising edge, with no padding byte.
- R2: With `req_page`=1 the header is eight bytes: 0xD2, the three address bytes in the same order as R1, then four bytes of 0x00. Data follows after that.
- R3: Chip select stays low without a break from the start of the header to the end of the last data byte. SCK is never high while chip select is high. Each request with a nonzero count makes exactly one chip-select assertion.
- R4: SPI mode 0. MOSI changes only when SCK falls (or before the first rise). MISO is sampled on SCK rising edges and assembled MSB first. SCK stays high for exactly SCK_DIV/2 system clocks in every pulse.
- R5: A request for N bytes makes exactly 8*(H+N) SCK pulses, where H is the header length from R1 or R2.
- R6: `rd_data` does not change and `rd_valid` stays high while `rd_ready` is low. Every data byte is delivered once, in address order, under any back-pressure pattern.
- R7: A request with a byte count of 0 pulses `done` on the next cycle. It never drives chip select low and never raises `busy`.
- R8: Between two transactions, chip select stays high for at least CS_GAP system clocks.
- R9: `busy` is high from the cycle after a request is accepted until the transaction ends. `done` pulses for one cycle as chip select rises. A `req` made while `busy` is high is ignored.
- R10: After reset, chip select is high, SCK is low, and `busy`, `done` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start a read; sampled when `busy` is low |
| req_page | input | 1 | 0: streaming read 0x03, 1: page read 0xD2 |
| req_addr | input | 24 | Start address |
| req_len | input | CNT_W | Number of data bytes to read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer accepts the byte |
| rd_data | output | 8 | Read byte |

## Verification
The bench includes a behavioural flash. It decodes the header bits it sees on MOSI and returns a byte pattern computed from the address. Because of this, a wrong opcode, a wrong address byte order, a missing or extra padding byte, or MISO sampled on the wrong edge each shows up as a different kind of mismatch. Both opcodes are run with directed cases: a single byte, a start address near the top of the address space, a zero count, and a request made during a busy transaction. These are followed by random addresses, lengths and opcodes. Consumer readiness is set to always, about half the time, or rarely. Running with full readiness confirms the unbroken chip-select and SCK timing. Running with sparse readiness exercises the SCK pause and checks that bytes are neither lost nor duplicated.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

  localparam logic [7:0] OPC_STREAM = 8'h03;
  localparam logic [7:0] OPC_PAGE   = 8'hD2;
  localparam logic [3:0] HDR_STREAM = 4'd4;
  localparam logic [3:0] HDR_PAGE   = 4'd8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_HOLD,
    ST_END,
    ST_GAP
  } seq_st_t;

  // Header byte at position idx; padding and data phases transmit zero.
  function automatic logic [7:0] hdr_byte(input logic page, input logic [23:0] addr,
                                          input logic [3:0] idx);
    logic [7:0] b;
    case (idx)
      4'd0:    b = page ? OPC_PAGE : OPC_STREAM;
      4'd1:    b = addr[23:16];
      4'd2:    b = addr[15:8];
      4'd3:    b = addr[7:0];
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/spi_rd_sckgen.sv
module spi_rd_sckgen #(
  parameter int SCK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sck,
  output logic rise,
  output logic fall
);
  localparam int HALF = SCK_DIV / 2;
  localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [HW-1:0] hcnt;
  logic          tick;

  assign tick = (hcnt == HW'(HALF - 1));
  assign rise = en && tick && !sck;
  assign fall = en && tick && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      sck  <= 1'b0;
    end else if (!en) begin
      hcnt <= '0;
      sck  <= 1'b0;
    end else if (tick) begin
      hcnt <= '0;
      sck  <= ~sck;
    end else begin
      hcnt <= hcnt + HW'(1);
    end
  end

  // R4: a disabled generator parks SCK low
  a_r4_sck_parks_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sck);

endmodule

// File: rtl/spi_rd_shifter.sv
module spi_rd_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       rise,
  input  logic       fall,
  input  logic       miso,
  output logic       mosi,
  output logic [7:0] rx_byte,
  output logic       byte_end
);
  logic [7:0] tx_q;
  logic [7:0] rx_q;
  logic [2:0] bit_q;

  assign mosi     = tx_q[7];
  assign rx_byte  = rx_q;
  assign byte_end = fall && (bit_q == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      bit_q <= '0;
    end else if (load) begin
      tx_q  <= load_byte;
      bit_q <= '0;
    end else if (fall) begin
      tx_q  <= {tx_q[6:0], 1'b0};
      bit_q <= bit_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rx_q <= '0;
    else if (rise) rx_q <= {rx_q[6:0], miso};
  end

  // R4: MOSI is held across the rising (sampling) edge
  a_r4_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> $stable(mosi));

endmodule

// File: rtl/spi_rd_seq.sv
module spi_rd_seq
  import spi_rd_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CS_GAP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_page,
  input  logic [23:0]      req_addr,
  input  logic [CNT_W-1:0] req_len,
  input  logic             byte_end,
  input  logic [7:0]       rx_byte,
  input  logic             rd_ready,
  output logic             busy,
  output logic             done,
  output logic             cs_n,
  output logic             clk_en,
  output logic             load,
  output logic [7:0]       load_byte,
  output logic             rd_valid,
  output logic [7:0]       rd_data
);
  localparam int GW = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;

  seq_st_t          st_q;
  logic             page_q;
  logic [23:0]      addr_q;
  logic [CNT_W-1:0] left_q;
  logic [3:0]       idx_q;
  logic [GW-1:0]    gap_q;
  logic             cs_n_q, done_q, vld_q;
  logic [7:0]       data_q;

  logic [3:0] hdr_len;
  logic       in_hdr, out_free, push, last;

  assign hdr_len  = page_q ? HDR_PAGE : HDR_STREAM;
  assign in_hdr   = idx_q < hdr_len;
  assign out_free = !vld_q || rd_ready;
  assign last     = (left_q == CNT_W'(1));
  assign push     = ((st_q == ST_SHIFT) && byte_end && !in_hdr && out_free) ||
                    ((st_q == ST_HOLD) && out_free);

  always_comb begin
    load      = 1'b0;
    load_byte = 8'h00;
    if (st_q == ST_IDLE && req && req_len != '0) begin
      load      = 1'b1;
      load_byte = req_page ? OPC_PAGE : OPC_STREAM;
    end else if (st_q == ST_SHIFT && byte_end) begin
      load      = 1'b1;
      load_byte = hdr_byte(page_q, addr_q, idx_q + 4'd1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      page_q <= 1'b0;
      addr_q <= '0;
      left_q <= '0;
      idx_q  <= '0;
      gap_q  <= '0;
      cs_n_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (req) begin
          if (req_len == '0) begin
            done_q <= 1'b1;
          end else begin
            page_q <= req_page;
            addr_q <= req_addr;
            left_q <= req_len;
            idx_q  <= '0;
            cs_n_q <= 1'b0;
            st_q   <= ST_SHIFT;
          end
        end
        ST_SHIFT: if (byte_end) begin
          if (in_hdr) begin
            idx_q <= idx_q + 4'd1;
          end else if (out_free) begin
            left_q <= left_q - CNT_W'(1);
            if (last) st_q <= ST_END;
          end else begin
            st_q <= ST_HOLD;
          end
        end
        ST_HOLD: if (out_free) begin
          left_q <= left_q - CNT_W'(1);
          st_q   <= last ? ST_END : ST_SHIFT;
        end
        ST_END: begin
          cs_n_q <= 1'b1;
          done_q <= 1'b1;
          gap_q  <= '0;
          st_q   <= ST_GAP;
        end
        ST_GAP: begin
          gap_q <= gap_q + GW'(1);
          if (gap_q == GW'(CS_GAP - 1)) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (push) begin
      vld_q  <= 1'b1;
      data_q <= rx_byte;
    end else if (rd_ready) begin
      vld_q  <= 1'b0;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign cs_n     = cs_n_q;
  assign clk_en   = (st_q == ST_SHIFT);
  assign rd_valid = vld_q;
  assign rd_data  = data_q;

  // R6: an offered byte is held until taken
  a_r6_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));
  // R7: zero count finishes at once without selecting the flash
  a_r7_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) && req && (req_len == '0) |=> cs_n && done && !busy);
  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3: select held low through shifting and stalls
  a_r3_cs_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SHIFT || st_q == ST_HOLD) |-> !cs_n);
  // R8: select stays high during the enforced gap
  a_r8_gap_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP) |-> cs_n);

endmodule

// File: rtl/spi_flash_reader.sv
module spi_flash_reader #(
  parameter int SCK_DIV = 4,
  parameter int CNT_W   = 16,
  parameter int CS_GAP  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_page,
  input  logic [23:0]      req_addr,
  input  logic [CNT_W-1:0] req_len,
  output logic             busy,
  output logic             done,
  output logic             spi_sck,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data
);
  logic       clk_en, rise, fall, load, byte_end;
  logic [7:0] load_byte, rx_byte;

  spi_rd_sckgen #(.SCK_DIV(SCK_DIV)) u_sck (
    .clk(clk), .rst_n(rst_n), .en(clk_en),
    .sck(spi_sck), .rise(rise), .fall(fall)
  );

  spi_rd_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_byte(load_byte),
    .rise(rise), .fall(fall), .miso(spi_miso),
    .mosi(spi_mosi), .rx_byte(rx_byte), .byte_end(byte_end)
  );

  spi_rd_seq #(.CNT_W(CNT_W), .CS_GAP(CS_GAP)) u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .req_page(req_page),
    .req_addr(req_addr), .req_len(req_len), .byte_end(byte_end),
    .rx_byte(rx_byte), .rd_ready(rd_ready), .busy(busy), .done(done),
    .cs_n(spi_cs_n), .clk_en(clk_en), .load(load), .load_byte(load_byte),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // R3: SCK idles low whenever the flash is deselected
  a_r3_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  // R9: completion only with the flash deselected
  a_r9_done_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> spi_cs_n);

endmodule

// File: tb/spi_flash_reader_tb_top.sv
`timescale 1ns/1ps
module spi_flash_reader_tb_top;
  localparam int SCK_DIV = 4;
  localparam int HALF    = SCK_DIV / 2;
  localparam int CNT_W   = 16;
  localparam int CS_GAP  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_page = 1'b0;
  logic [23:0] req_addr = '0;
  logic [CNT_W-1:0] req_len = '0;
  logic busy, done, spi_sck, spi_cs_n, spi_mosi, rd_valid;
  logic spi_miso = 1'b0;
  logic rd_ready = 1'b0;
  logic [7:0] rd_data;

  always #2.5 clk = ~clk;

  spi_flash_reader #(.SCK_DIV(SCK_DIV), .CNT_W(CNT_W), .CS_GAP(CS_GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_page(req_page), .req_addr(req_addr),
    .req_len(req_len), .busy(busy), .done(done), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  int n_chk = 0, n_bad = 0;
  int ready_pct = 100;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd29;
    return m ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'hA5;
  endfunction

  // flash model
  logic [7:0] m_hdr [0:7];
  logic [7:0] m_sh = '0;
  int m_bits = 0;

  initial forever begin
    @(negedge spi_cs_n);
    m_bits = 0;
    for (int i = 0; i < 8; i++) m_hdr[i] = 8'h00;
  end

  initial forever begin
    @(posedge spi_sck);
    m_sh = {m_sh[6:0], spi_mosi};
    if (m_bits < 64 && (m_bits % 8) == 7) m_hdr[m_bits / 8] = m_sh;
    m_bits++;
  end

  initial forever begin
    @(negedge spi_sck);
    if (!spi_cs_n && m_bits >= 8) begin
      int hb;
      hb = (m_hdr[0] == 8'hD2) ? 64 : 32;
      if (m_bits >= hb) begin
        int d;
        logic [7:0] b;
        d = m_bits - hb;
        b = mem_byte({m_hdr[1], m_hdr[2], m_hdr[3]} + 24'(d / 8));
        spi_miso = b[7 - (d % 8)];
      end else spi_miso = 1'b0;
    end else spi_miso = 1'b0;
  end

  // consumer readiness
  initial forever begin
    @(posedge clk); #1;
    rd_ready = ($urandom_range(99) < ready_pct);
  end

  // monitor
  logic [7:0] rx_buf [0:63];
  int rx_n = 0;
  int mosi_err = 0, width_err = 0, idle_err = 0, gap_err = 0, stab_err = 0;
  int hi_run = 0, cs_run = 0, n_cs_fall = 0;
  bit seen_txn = 0, done_seen = 0, busy_seen = 0;
  logic p_sck = 0, p_mosi = 0, p_cs = 1, p_stall = 0;
  logic [7:0] p_data = '0;

  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (spi_sck && spi_cs_n) idle_err++;
      if (spi_sck && p_sck && spi_mosi != p_mosi) mosi_err++;
      if (spi_sck) hi_run++;
      else begin
        if (p_sck && hi_run != HALF) width_err++;
        hi_run = 0;
      end
      if (spi_cs_n) cs_run++;
      else begin
        if (p_cs) begin
          if (seen_txn && cs_run < CS_GAP) gap_err++;
          seen_txn = 1;
          n_cs_fall++;
        end
        cs_run = 0;
      end
      if (done) done_seen = 1;
      if (busy) busy_seen = 1;
      if (p_stall && (!rd_valid || rd_data != p_data)) stab_err++;
      if (rd_valid && rd_ready && rx_n < 64) begin
        rx_buf[rx_n] = rd_data;
        rx_n++;
      end
      p_stall = rd_valid && !rd_ready;
      p_data  = rd_data;
      p_sck   = spi_sck;
      p_mosi  = spi_mosi;
      p_cs    = spi_cs_n;
    end
  end

  task automatic run_txn(input logic page, input logic [23:0] addr, input int len,
                         input bit inject);
    int base, hb, lim;
    string tg;
    tg = page ? "R2" : "R1";
    hb = page ? 8 : 4;
    while (busy) @(negedge clk);
    rx_n = 0;
    done_seen = 0;
    base = n_cs_fall;
    @(posedge clk); #1;
    req = 1; req_page = page; req_addr = addr; req_len = CNT_W'(len);
    @(posedge clk); #1;
    req = 0;
    if (inject) begin
      repeat (30) @(posedge clk);
      #1;
      req = 1; req_page = ~page; req_addr = ~addr; req_len = 16'd2;
      @(posedge clk); #1;
      req = 0;
    end
    lim = 0;
    while (!done_seen && lim < 40000) begin @(negedge clk); lim++; end
    chk(done_seen, "R9 done pulse", done_seen, 1);
    lim = 0;
    while (rd_valid && lim < 2000) begin @(negedge clk); lim++; end
    chk(n_cs_fall - base == 1, inject ? "R9 busy req ignored" : "R3 one select",
        n_cs_fall - base, 1);
    chk(m_hdr[0] == (page ? 8'hD2 : 8'h03), {tg, " opcode"}, m_hdr[0], page ? 8'hD2 : 8'h03);
    chk({m_hdr[1], m_hdr[2], m_hdr[3]} == addr, {tg, " address"},
        {m_hdr[1], m_hdr[2], m_hdr[3]}, addr);
    if (page)
      chk({m_hdr[4], m_hdr[5], m_hdr[6], m_hdr[7]} == 32'h0, "R2 padding",
          {m_hdr[4], m_hdr[5], m_hdr[6], m_hdr[7]}, 0);
    chk(m_bits == 8 * (hb + len), "R5 pulse count", m_bits, 8 * (hb + len));
    chk(rx_n == len, "R6 byte count", rx_n, len);
    for (int i = 0; i < len && i < rx_n; i++)
      chk(rx_buf[i] == mem_byte(addr + 24'(i)), "R4 data byte", rx_buf[i],
          mem_byte(addr + 24'(i)));
  endtask

  task automatic run_zero(input logic page);
    int base;
    while (busy) @(negedge clk);
    done_seen = 0; busy_seen = 0;
    base = n_cs_fall;
    @(posedge clk); #1;
    req = 1; req_page = page; req_addr = 24'h123456; req_len = '0;
    @(posedge clk); #1;
    req = 0;
    @(negedge clk);
    chk(done_seen, "R7 immediate done", done_seen, 1);
    repeat (3) @(negedge clk);
    chk(n_cs_fall == base, "R7 no select", n_cs_fall - base, 0);
    chk(!busy_seen, "R7 never busy", busy_seen, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(spi_cs_n == 1'b1, "R10 reset cs", spi_cs_n, 1);
    chk(spi_sck == 1'b0, "R10 reset sck", spi_sck, 0);
    chk({busy, done, rd_valid} == 3'b000, "R10 reset flags", {busy, done, rd_valid}, 0);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    ready_pct = 100;
    run_txn(1'b0, 24'h000000, 1, 0);
    run_txn(1'b1, 24'h000100, 1, 0);
    run_zero(1'b0);
    run_zero(1'b1);
    run_txn(1'b0, 24'hFFFFFE, 4, 0);
    run_txn(1'b1, 24'hABCDEF, 5, 1);
    ready_pct = 10;
    run_txn(1'b0, 24'h5A5A00, 6, 0);
    run_txn(1'b1, 24'h00FFFF, 6, 0);
    for (int t = 0; t < 30; t++) begin
      int sel;
      sel = $urandom_range(2);
      ready_pct = (sel == 0) ? 100 : (sel == 1) ? 50 : 15;
      run_txn(1'($urandom_range(1)), 24'($urandom), $urandom_range(1, 9), 0);
    end
    repeat (10) @(negedge clk);

    chk(mosi_err == 0, "R4 mosi moved while sck high", mosi_err, 0);
    chk(width_err == 0, "R4 sck high width", width_err, 0);
    chk(idle_err == 0, "R3 sck high while deselected", idle_err, 0);
    chk(gap_err == 0, "R8 select gap", gap_err, 0);
    chk(stab_err == 0, "R6 held offer", stab_err, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule